// File: doc/BRIEF.md
# Command Line Receive Buffer

This block stores incoming characters in a circular byte store and tells a downstream consumer when at least one complete command line is waiting. A character source offers one byte per cycle with a valid strobe. Each accepted byte, the terminator included, is written at the write index, and the write index then steps forward and wraps to zero after the last slot. A carriage return (0x0D) ends a command line.

The consumer pulls bytes one at a time from the read index. The popped byte appears on a registered output one cycle later. When the consumer has pulled a terminator, the count of waiting commands drops by one. Reading and writing go through separate indices and can happen in the same cycle. A write that arrives while the store is full is discarded and sets a sticky overflow flag. The flag stays set until the consumer clears it.

Top module: `cmdline_rx_buf`

## Requirements
- R1: After synchronous reset, empty is 1, full is 0, level is 0, cmds_pending is 0, cmd_ready is 0, overflow is 0 and rd_valid is 0.
- R2: Bytes leave in the order they were accepted. A pop is a cycle with rd_en high while empty is 0. On the next cycle it drives the popped byte on rd_data, with rd_valid high for exactly that cycle.
- R3: The write index wraps from slot DEPTH-1 to slot 0, and so does the read index. Ordering holds across any number of wraps over long mixed traffic.
- R4: The level rises by one on an accepted write and falls by one on a pop. It is unchanged when both happen in the same cycle. full is 1 exactly when level equals DEPTH, and empty is 1 exactly when level is 0.
- R5: A write offered while full is 1 is dropped: level and the stored bytes are unchanged. The overflow flag is 1 on the next cycle and stays set.
- R6: ovf_clr clears overflow on the next cycle. If a dropped write and ovf_clr occur in the same cycle, overflow stays 1.
- R7: rd_en while empty is ignored: rd_valid is 0 on the next cycle and level is unchanged.
- R8: cmds_pending rises by one for each accepted write of 0x0D. Other byte values do not change it, and neither does a dropped 0x0D.
- R9: cmds_pending falls by one in the cycle after rd_data shows 0x0D with rd_valid high. cmd_ready is 1 exactly when cmds_pending is non-zero.
- R10: A synchronous reset asserted in the middle of traffic returns every output to the R1 state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A character is offered this cycle |
| wr_data | input | 8 | Offered character |
| rd_en | input | 1 | Consumer pops one byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_data | output | 8 | Popped byte, valid when rd_valid is 1 |
| rd_valid | output | 1 | rd_data holds a byte popped last cycle |
| empty | output | 1 | No bytes stored |
| full | output | 1 | DEPTH bytes stored |
| level | output | $clog2(DEPTH+1) (8) | Stored byte count |
| cmds_pending | output | $clog2(DEPTH+1) (8) | Terminated commands not yet popped |
| cmd_ready | output | 1 | At least one command waiting |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Several stimulus patterns are used.

- **Short terminated lines that are read straight out:** these separate a per-command ready count from a per-byte one, and show the one-cycle lag of the count behind the popped terminator.
- **Filling to capacity and pushing one more terminator:** this separates a dropped write from a stored one, checks that the dropped byte does not reach the command count, and tests the set-over-clear priority of the overflow flag.
- **Long random traffic with simultaneous reads and writes:** write and read rates are mixed, so both indices wrap many times. This exposes off-by-one errors at the wrap point and level errors on cycles that both write and read.
- **Reset in the middle of traffic:** this confirms that no state survives a reset.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  typedef logic [7:0] char_t;
  localparam char_t CR_CHAR = 8'h0D;
endpackage

// File: rtl/cmdbuf_ram.sv
// Simple dual-port store, registered read, no reset (block RAM friendly).
module cmdbuf_ram #(
  parameter int DEPTH = 200,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmdbuf_ptr.sv
// Wrapping index; a power-of-two depth uses natural rollover.
module cmdbuf_ptr #(
  parameter int DEPTH = 200,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst)      idx <= '0;
        else if (inc) idx <= idx + AW'(1);
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)      idx <= '0;
        else if (inc) idx <= (idx == LAST) ? '0 : idx + AW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/cmdbuf_tracker.sv
// Waiting-command count and sticky overflow flag.
module cmdbuf_tracker #(
  parameter int DEPTH = 200,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          term_push,
  input  logic          term_pop,
  input  logic          ovf_set,
  input  logic          ovf_clr,
  output logic [CW-1:0] pending,
  output logic          overflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else begin
      case ({term_push, term_pop})
        2'b10:   pending <= pending + CW'(1);
        2'b01:   pending <= pending - CW'(1);
        default: pending <= pending;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          overflow <= 1'b0;
    else if (ovf_set) overflow <= 1'b1;
    else if (ovf_clr) overflow <= 1'b0;
  end
endmodule

// File: rtl/cmdline_rx_buf.sv
module cmdline_rx_buf
  import cmdbuf_pkg::*;
#(
  parameter int DEPTH = 200,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic          ovf_clr,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level,
  output logic [CW-1:0] cmds_pending,
  output logic          cmd_ready,
  output logic          overflow
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [AW-1:0] wr_idx, rd_idx;
  logic          wr_ok, rd_ok;
  logic          term_push, term_pop;

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);
  assign wr_ok = wr_valid && !full;
  assign rd_ok = rd_en && !empty;

  assign term_push = wr_ok && (char_t'(wr_data) == CR_CHAR);
  assign term_pop  = rd_valid && (char_t'(rd_data) == CR_CHAR);

  cmdbuf_ptr #(.DEPTH(DEPTH)) u_wptr (.clk(clk), .rst(rst), .inc(wr_ok), .idx(wr_idx));
  cmdbuf_ptr #(.DEPTH(DEPTH)) u_rptr (.clk(clk), .rst(rst), .inc(rd_ok), .idx(rd_idx));

  cmdbuf_ram #(.DEPTH(DEPTH), .W(8)) u_ram (
    .clk(clk), .we(wr_ok), .waddr(wr_idx), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_idx), .rdata(rd_data)
  );

  cmdbuf_tracker #(.DEPTH(DEPTH)) u_trk (
    .clk(clk), .rst(rst), .term_push(term_push), .term_pop(term_pop),
    .ovf_set(wr_valid && full), .ovf_clr(ovf_clr),
    .pending(cmds_pending), .overflow(overflow)
  );

  assign cmd_ready = (cmds_pending != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/cmdbuf_chk.sv
module cmdbuf_chk #(
  parameter int DEPTH = 200,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          rd_en,
  input logic          ovf_clr,
  input logic          empty,
  input logic          full,
  input logic          rd_valid,
  input logic [CW-1:0] level,
  input logic [CW-1:0] cmds_pending,
  input logic          overflow
);
  assert_pop_shows_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid);

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && rd_en && !full && !empty) |=> (level == $past(level)));

  assert_full_stays_R5: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full) |=> overflow);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow);

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_valid) |=> (!rd_valid && empty));

  assert_pending_bound_R8: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cmds_pending} <= {1'b0, level} + (CW+1)'(rd_valid)));
endmodule

bind cmdline_rx_buf cmdbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_en(rd_en), .ovf_clr(ovf_clr),
  .empty(empty), .full(full), .rd_valid(rd_valid), .level(level),
  .cmds_pending(cmds_pending), .overflow(overflow)
);

// File: tb/tb_cmdline_rx_buf.sv
module tb_cmdline_rx_buf;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 200;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic rd_valid, empty, full, cmd_ready, overflow;
  logic [CW-1:0] level, cmds_pending;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  // Reference model state
  logic [7:0] q[$];
  int  m_pend = 0;
  bit  m_ovf = 0, m_rv = 0;
  logic [7:0] m_rd = 8'h00;

  always #(PERIOD/2) clk = ~clk;

  cmdline_rx_buf #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .rd_en(rd_en),
    .ovf_clr(ovf_clr), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
    .full(full), .level(level), .cmds_pending(cmds_pending), .cmd_ready(cmd_ready),
    .overflow(overflow)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      q.delete(); m_pend = 0; m_ovf = 0; m_rv = 0;
    end else begin
      automatic bit was_full = (q.size() == DEPTH);
      automatic bit pop  = rd_en && (q.size() > 0);
      automatic bit push = wr_valid && !was_full;
      automatic bit dec  = m_rv && (m_rd == 8'h0D);
      m_rv = pop;
      if (pop) m_rd = q.pop_front();
      if (push) begin
        q.push_back(wr_data);
        if (wr_data == 8'h0D) m_pend++;
      end
      if (dec) m_pend--;
      if (wr_valid && was_full) m_ovf = 1;
      else if (ovf_clr)         m_ovf = 0;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(level, q.size(), "R4 level");
      chk(full, q.size() == DEPTH, "R4 full");
      chk(empty, q.size() == 0, "R4 empty");
      chk(overflow, m_ovf, "R5/R6 overflow");
      chk(cmds_pending, m_pend, "R8 pending");
      chk(cmd_ready, m_pend != 0, "R9 cmd_ready");
      chk(rd_valid, m_rv, "R2/R7 rd_valid");
      if (m_rv) chk(rd_data, m_rd, "R2/R3 rd_data");
    end
  end

  task automatic step(input bit wv, input logic [7:0] wd, input bit re, input bit clr);
    wr_valid = wv; wr_data = wd; rd_en = re; ovf_clr = clr;
    @(negedge clk);
    wr_valid = 0; rd_en = 0; ovf_clr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(empty, 1, "R1 empty"); chk(full, 0, "R1 full"); chk(level, 0, "R1 level");
    chk(cmds_pending, 0, "R1 pending"); chk(cmd_ready, 0, "R1 cmd_ready");
    chk(overflow, 0, "R1 overflow"); chk(rd_valid, 0, "R1 rd_valid");

    // R8: one terminated line, then an unterminated tail
    step(1, "G", 0, 0); step(1, "O", 0, 0); step(1, 8'h0D, 0, 0);
    chk(cmds_pending, 1, "R8 one line"); chk(cmd_ready, 1, "R9 ready after CR");
    step(1, "a", 0, 0); step(1, "b", 0, 0);
    chk(cmds_pending, 1, "R8 plain bytes no count");

    // R2/R9: pop the line
    step(0, 0, 1, 0); chk(rd_data, "G", "R2 first byte");
    step(0, 0, 1, 0); chk(rd_data, "O", "R2 second byte");
    step(0, 0, 1, 0); chk(rd_data, 8'h0D, "R2 terminator"); chk(cmds_pending, 1, "R9 lag");
    step(0, 0, 0, 0); chk(cmds_pending, 0, "R9 decrement"); chk(cmd_ready, 0, "R9 ready low");
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    // R7: reads when empty
    step(0, 0, 1, 0); chk(rd_valid, 0, "R7 empty read"); chk(level, 0, "R7 level");
    step(0, 0, 1, 0); chk(rd_valid, 0, "R7 empty read 2");

    // R4/R5: fill to capacity
    for (int i = 0; i < DEPTH; i++)
      step(1, (i % 10 == 9) ? 8'h0D : 8'(8'h41 + i % 26), 0, 0);
    chk(full, 1, "R4 full at DEPTH"); chk(cmds_pending, 20, "R8 pending at full");
    step(1, 8'h0D, 0, 0);
    chk(overflow, 1, "R5 overflow set"); chk(level, DEPTH, "R5 level kept");
    chk(cmds_pending, 20, "R8 dropped CR not counted");
    // R6: set wins over clear, then clear alone
    step(1, 8'h33, 0, 1); chk(overflow, 1, "R6 set wins");
    step(0, 0, 0, 1); chk(overflow, 0, "R6 clear");
    // write and read while full: write dropped, read taken
    step(1, 8'h55, 1, 0); chk(level, DEPTH - 1, "R5 full write dropped");
    step(1, 8'h56, 1, 0); chk(level, DEPTH - 1, "R4 simultaneous hold");

    // R3: long mixed traffic across many wraps
    for (int ph = 0; ph < 6; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        automatic int wp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
        automatic bit wv = ($urandom % 100) < wp;
        automatic bit re = ($urandom % 100) < (100 - wp);
        automatic logic [7:0] d = (($urandom % 6) == 0) ? 8'h0D : 8'($urandom);
        step(wv, d, re, ($urandom % 40) == 0);
      end
    end

    // R10: reset in the middle of traffic
    for (int c = 0; c < 30; c++) step(1, (c % 4 == 3) ? 8'h0D : 8'h61, c % 3 == 0, 0);
    rst = 1; step(1, 8'h0D, 1, 0); rst = 0;
    chk(empty, 1, "R10 empty"); chk(level, 0, "R10 level");
    chk(cmds_pending, 0, "R10 pending"); chk(overflow, 0, "R10 overflow");
    chk(rd_valid, 0, "R10 rd_valid");
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule